// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Reload

This block is a 16-bit up-counter that steps only on machine-cycle strobes. Its count source is set by a mode field. It can stay stopped, count every machine cycle, count machine cycles while an external gate level is high, or count falling edges on an external pin. Both external pins are sampled once per machine cycle. A falling edge is recognised when one sample reads high and the sample that follows reads low.

A reload register is written by software. It can be copied into the counter in one of two ways: in place of the zero value when the counter wraps, or when a falling edge arrives on a separate trigger pin. Two sticky request flags feed one interrupt line. One flag records a wrap and the other records an external reload. Each flag stays set until software clears it with its own strobe.

Top module: `evt_timer16`

## Requirements
- R1: A synchronous reset sets the counter to 0000h, clears both flags and clears both pin sample histories.
- R2: Counter, flags and pin samples change only on clock edges where `mc_tick` is high. The only exceptions are reload-register writes and flag clears.
- R3: `src_sel` 00 keeps the counter stopped. `src_sel` 01 adds one on every tick, whatever the level of `cnt_pin`.
- R4: With `src_sel` 11 (gated), a tick adds one only when the `cnt_pin` sample taken at the previous tick was high.
- R5: With `src_sel` 10 (event), one falling edge adds exactly one. The increment is visible after the tick that follows the tick whose sample read low after a high sample.
- R6: In every counting mode, a step from FFFFh sets `ovf_flag`. With `rld_sel[1]` = 0 the counter then reads 0000h.
- R7: With `rld_sel` = 10, a step from FFFFh loads the reload register on that same tick, so 0000h never appears.
- R8: With `rld_sel` = 11, a falling edge on `rld_pin` loads the reload register at the tick after the detection tick, and not before.
- R9: The edge in R8 sets `ext_flag` only when `ext_en` is 1.
- R10: Each flag stays set until its clear strobe. When a set and a clear fall on the same clock, the set wins.
- R11: `irq` is high exactly when `irq_en` is 1 and at least one flag is set.
- R12: The reload register takes `rld_wdata` on any clock where `rld_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 1 | Event input or gate level |
| rld_pin | input | 1 | External reload trigger |
| src_sel | input | 2 | Count source: 00 stop, 01 timer, 10 event, 11 gated |
| rld_sel | input | 2 | Reload: 0x none, 10 on wrap, 11 on trigger edge |
| ext_en | input | 1 | Allows the trigger edge to set `ext_flag` |
| irq_en | input | 1 | Interrupt enable |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| ext_clr | input | 1 | Clears `ext_flag` |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Wrap request flag |
| ext_flag | output | 1 | External reload request flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A hardware flag set and a software clear of the same flag can land on one clock. The bench arranges this by raising `ovf_clr` on the very tick that wraps the counter in wrap-reload mode. It also raises `ext_clr` on the tick that acts on a detected trigger edge. In each case it expects the flag to read 1 afterwards, and it expects the counter to hold the reload value rather than 0000h.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned TMR_W = 16;

    typedef enum logic [1:0] {
        SRC_STOP  = 2'b00,
        SRC_TIMER = 2'b01,
        SRC_EVENT = 2'b10,
        SRC_GATED = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        RLD_NONE = 2'b00,
        RLD_WRAP = 2'b10,
        RLD_EDGE = 2'b11
    } rld_e;

    typedef struct packed {
        logic lvl;
        logic fall;
    } pin_obs_t;

    function automatic rld_e rld_decode(input logic [1:0] sel);
        if (!sel[1])
            return RLD_NONE;
        return sel[0] ? RLD_EDGE : RLD_WRAP;
    endfunction

    function automatic logic src_step(input src_e src, input pin_obs_t obs);
        case (src)
            SRC_TIMER: return 1'b1;
            SRC_EVENT: return obs.fall;
            SRC_GATED: return obs.lvl;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler
    import evt_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     pin,
    output pin_obs_t obs
);
    logic smp_now;
    logic smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else if (tick) begin
            smp_now <= pin;
            smp_old <= smp_now;
        end
    end

    always_comb begin
        obs.lvl  = smp_now;
        obs.fall = smp_old & ~smp_now;
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import evt_timer_pkg::*;
#(
    parameter int unsigned W = TMR_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  src_e         src,
    input  rld_e         rld,
    input  pin_obs_t     cnt_obs,
    input  pin_obs_t     trg_obs,
    input  logic         ext_en,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rld_q,
    output logic         wrap_evt,
    output logic         edge_evt
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic step;
    logic wrap;
    logic edge_ld;
    logic take_rld;

    always_comb begin
        step     = src_step(src, cnt_obs);
        wrap     = step && (cnt_q == ALL_ONES);
        edge_ld  = (rld == RLD_EDGE) && trg_obs.fall;
        take_rld = edge_ld || (wrap && rld == RLD_WRAP);
        wrap_evt = tick && wrap;
        edge_evt = tick && edge_ld && ext_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rld_q <= '0;
        else if (rld_wr)
            rld_q <= rld_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick) begin
            if (take_rld)
                cnt_q <= rld_q;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_req_flags.sv
module tmr_req_flags #(
    parameter int unsigned N = 2
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         en,
    output logic [N-1:0] flag_q,
    output logic         req
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[g] <= 1'b0;
            else if (set_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g])
                flag_q[g] <= 1'b0;
        end
    end

    assign req = en && (|flag_q);
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mc_tick,
    input  logic        cnt_pin,
    input  logic        rld_pin,
    input  logic [1:0]  src_sel,
    input  logic [1:0]  rld_sel,
    input  logic        ext_en,
    input  logic        irq_en,
    input  logic        rld_wr,
    input  logic [15:0] rld_wdata,
    input  logic        ovf_clr,
    input  logic        ext_clr,
    output logic [15:0] count,
    output logic        ovf_flag,
    output logic        ext_flag,
    output logic        irq
);
    localparam int unsigned NFLAG = 2;

    pin_obs_t         cnt_obs;
    pin_obs_t         trg_obs;
    logic [15:0]      rld_q;
    logic             wrap_evt;
    logic             edge_evt;
    logic [NFLAG-1:0] flags;

    tmr_pin_sampler u_cnt_smp (
        .clk(clk), .rst(rst), .tick(mc_tick), .pin(cnt_pin), .obs(cnt_obs)
    );

    tmr_pin_sampler u_trg_smp (
        .clk(clk), .rst(rst), .tick(mc_tick), .pin(rld_pin), .obs(trg_obs)
    );

    tmr_count_core #(.W(16)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (mc_tick),
        .src      (src_e'(src_sel)),
        .rld      (rld_decode(rld_sel)),
        .cnt_obs  (cnt_obs),
        .trg_obs  (trg_obs),
        .ext_en   (ext_en),
        .rld_wr   (rld_wr),
        .rld_wdata(rld_wdata),
        .cnt_q    (count),
        .rld_q    (rld_q),
        .wrap_evt (wrap_evt),
        .edge_evt (edge_evt)
    );

    tmr_req_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i ({edge_evt, wrap_evt}),
        .clr_i ({ext_clr, ovf_clr}),
        .en    (irq_en),
        .flag_q(flags),
        .req   (irq)
    );

    assign ovf_flag = flags[0];
    assign ext_flag = flags[1];
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk (
    input logic        clk,
    input logic        rst,
    input logic        mc_tick,
    input logic [1:0]  src_sel,
    input logic [1:0]  rld_sel,
    input logic        ext_en,
    input logic        irq_en,
    input logic        ovf_clr,
    input logic        ext_clr,
    input logic [15:0] count,
    input logic [15:0] rld_q,
    input logic        ovf_flag,
    input logic        ext_flag,
    input logic        irq
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == 16'h0 && !ovf_flag && !ext_flag));

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !mc_tick |=> ($stable(count) && !$rose(ovf_flag) && !$rose(ext_flag)));

    p_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (mc_tick && src_sel == 2'b00 && rld_sel != 2'b11) |=> $stable(count));

    p_timer_r3: assert property (@(posedge clk) disable iff (rst)
        (mc_tick && src_sel == 2'b01 && rld_sel != 2'b11 && count != 16'hFFFF)
        |=> count == $past(count) + 16'd1);

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (mc_tick && src_sel == 2'b01 && count == 16'hFFFF) |=> ovf_flag);

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (mc_tick && src_sel == 2'b01 && !rld_sel[1] && count == 16'hFFFF)
        |=> count == 16'h0);

    p_wrap_load_r7: assert property (@(posedge clk) disable iff (rst)
        (mc_tick && src_sel == 2'b01 && rld_sel == 2'b10 && count == 16'hFFFF)
        |=> count == $past(rld_q));

    p_ext_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!ext_flag && !ext_en) |=> !ext_flag);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_sticky_ext_r10: assert property (@(posedge clk) disable iff (rst)
        (ext_flag && !ext_clr) |=> ext_flag);

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);
endmodule

bind evt_timer16 evt_timer16_chk u_chk (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .src_sel(src_sel),
    .rld_sel(rld_sel), .ext_en(ext_en), .irq_en(irq_en),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count(count), .rld_q(rld_q),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
);

// File: tb/evt_timer16_tb_top.sv
`timescale 1ns/1ps
module evt_timer16_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mc_tick = 1'b0;
    logic        cnt_pin = 1'b1;
    logic        rld_pin = 1'b1;
    logic [1:0]  src_sel = 2'b00;
    logic [1:0]  rld_sel = 2'b00;
    logic        ext_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        rld_wr = 1'b0;
    logic [15:0] rld_wdata = 16'h0;
    logic        ovf_clr = 1'b0;
    logic        ext_clr = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;
    logic        ext_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    localparam int LIMIT = 150000;

    always #5 clk = ~clk;

    evt_timer16 dut_i (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .rld_pin(rld_pin), .src_sel(src_sel), .rld_sel(rld_sel),
        .ext_en(ext_en), .irq_en(irq_en), .rld_wr(rld_wr),
        .rld_wdata(rld_wdata), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
        .count(count), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
    );

    // pat: 0 hold low, 1 hold high, 2 toggle (low before even ticks)
    typedef struct packed {
        logic [1:0]  src;
        logic [1:0]  pat;
        logic [7:0]  n;
        logic [15:0] delta;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'b01, 2'd0, 8'd5, 16'd5},
        '{2'b01, 2'd2, 8'd6, 16'd6},
        '{2'b10, 2'd2, 8'd6, 16'd3},
        '{2'b10, 2'd2, 8'd7, 16'd3},
        '{2'b10, 2'd1, 8'd4, 16'd0},
        '{2'b10, 2'd0, 8'd4, 16'd1},
        '{2'b11, 2'd1, 8'd5, 16'd5},
        '{2'b11, 2'd0, 8'd5, 16'd1},
        '{2'b11, 2'd2, 8'd5, 16'd3},
        '{2'b00, 2'd2, 8'd6, 16'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic oc, input logic ec);
        @(negedge clk);
        mc_tick = 1'b1; ovf_clr = oc; ext_clr = ec;
        @(negedge clk);
        mc_tick = 1'b0; ovf_clr = 1'b0; ext_clr = 1'b0;
    endtask

    task automatic write_rld(input logic [15:0] v);
        @(negedge clk);
        rld_wr = 1'b1; rld_wdata = v;
        @(negedge clk);
        rld_wr = 1'b0;
    endtask

    task automatic load_ext(input logic [15:0] v);
        src_sel = 2'b00;
        rld_sel = 2'b11;
        write_rld(v);
        rld_pin = 1'b1;
        tick(0, 0); tick(0, 0);
        rld_pin = 1'b0;
        tick(0, 0); tick(0, 0);
        rld_pin = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] start;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count", count, 16'h0);
        check("R1 flags", {ovf_flag, ext_flag}, 2'b00);

        for (int i = 0; i < 10; i++) begin
            src_sel = 2'b00;
            cnt_pin = 1'b1;
            tick(0, 0); tick(0, 0);
            start = count;
            src_sel = VECS[i].src;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                cnt_pin = (VECS[i].pat == 2'd2) ? k[0] : VECS[i].pat[0];
                tick(0, 0);
            end
            check($sformatf("R3/R4/R5 vector %0d", i), count, start + VECS[i].delta);
        end
        src_sel = 2'b00;

        // R8 timing and R9 gating (ext_en low)
        rld_sel = 2'b11;
        write_rld(16'hFFFE);
        rld_pin = 1'b1;
        tick(0, 0); tick(0, 0);
        start = count;
        rld_pin = 1'b0;
        tick(0, 0);
        check("R8 no early load", count, start);
        tick(0, 0);
        check("R8 load after detect", count, 16'hFFFE);
        check("R9 ext flag gated", ext_flag, 1'b0);
        rld_pin = 1'b1;

        // R6 plain wrap
        rld_sel = 2'b00;
        src_sel = 2'b01;
        tick(0, 0);
        check("R6 at FFFF", count, 16'hFFFF);
        tick(0, 0);
        check("R6 wraps to zero", count, 16'h0);
        check("R6 ovf set", ovf_flag, 1'b1);
        check("R11 masked", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R11 enabled", irq, 1'b1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R10 clear", ovf_flag, 1'b0);
        check("R11 drops", irq, 1'b0);

        // R2 no tick, no change
        src_sel = 2'b01;
        start = count;
        repeat (10) @(negedge clk);
        check("R2 idle", count, start);

        // R7 wrap reload with simultaneous clear (R10), R12 write
        load_ext(16'hFFFF);
        check("R8 preload", count, 16'hFFFF);
        write_rld(16'h1234);
        rld_sel = 2'b10;
        src_sel = 2'b01;
        tick(1, 0);
        check("R7 reload on wrap", count, 16'h1234);
        check("R10 set beats clear ovf", ovf_flag, 1'b1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;

        // R9 ext flag with ext_en, set beats clear
        src_sel = 2'b00;
        ext_en = 1'b1;
        rld_sel = 2'b11;
        write_rld(16'h00AA);
        rld_pin = 1'b1;
        tick(0, 0); tick(0, 0);
        rld_pin = 1'b0;
        tick(0, 0);
        tick(0, 1);
        check("R8 edge load", count, 16'h00AA);
        check("R9 ext flag set", ext_flag, 1'b1);
        check("R10 set beats clear ext", ext_flag, 1'b1);
        check("R11 ext irq", irq, 1'b1);
        @(negedge clk); ext_clr = 1'b1;
        @(negedge clk); ext_clr = 1'b0;
        check("R10 ext clear", ext_flag, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule